// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the control unit of a CPU whose registers share one internal bus. A step counter walks through the control steps of each instruction. A decoder turns the counter into one-hot time-slot lines T1 to T7. A second decoder turns the opcode field of the instruction register into one-hot instruction lines. Every gating and strobe signal is a sum of products of these time slots, the instruction lines and the negative condition flag. When the encoder raises End, the counter goes back to T1, so the next instruction fetch begins.

The counter is a state machine with seven named states, ST_T1 to ST_T7. It has three transitions. In *advance*, the counter moves from ST_Tk to ST_Tk+1. This happens when the external run input is high and the current step is not waiting on memory, or is waiting and memory-complete is high. In *restart*, the counter moves to ST_T1 when End is high on an advancing cycle. In *hold*, the counter keeps its state in every other cycle. An active-low reset forces ST_T1.

Four instruction kinds are decoded from ir_opcode: add with a memory-indirect source (`Rd <- M[Rs] + Rd`), unconditional relative branch, branch-if-negative, and undefined. The block also outputs the branch displacement, sign-extended, for the offset gate.

Top module: `hwctl_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, step_o is 7'b0000001 (T1 in bit 0). In that state end_o is low.
- R2: step_o is always one-hot, with bit k-1 for step Tk. Each advancing cycle moves it by exactly one step, unless End is high.
- R3: While run is low, the step does not change.
- R4: In T2, and in T5 of an add, wait_mfc is high. The step holds until mfc is high, and then advances.
- R5: The fetch steps are the same for every opcode. T1 raises pc_out, mar_in, mem_read, alu_carry_in, alu_add and z_in. T2 raises z_out, pc_in and wait_mfc. T3 raises mdr_out and ir_in.
- R6: Add (ir_opcode 4'h1) has four execute steps. T4 raises src_out, mar_in and mem_read. T5 raises dst_out, y_in and wait_mfc. T6 raises mdr_out, alu_add and z_in. T7 raises z_out, dst_in and end_o.
- R7: Branch (ir_opcode 4'h2) has three execute steps. T4 raises pc_out and y_in. T5 raises offset_out, alu_add and z_in. T6 raises z_out, pc_in and end_o.
- R8: Branch-if-negative (ir_opcode 4'h3) follows R7 when flag_n is 1. When flag_n is 0, it raises pc_out, y_in and end_o at T4, and no later step is reached.
- R9: Any other opcode raises end_o at T4, and no other control output at that step.
- R10: At most one of pc_out, z_out, mdr_out, src_out, dst_out and offset_out is high in any cycle.
- R11: offset_ext equals ir_offset, sign-extended from 8 to 32 bits.
- R12: After an advancing cycle with end_o high, the next step is T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Lets the step counter advance |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| ir_offset | input | 8 | Branch displacement field of the instruction register |
| flag_n | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory operation complete |
| step_o | output | 7 | One-hot time slot, bit 0 = T1 |
| pc_out | output | 1 | Drive PC onto the bus |
| pc_in | output | 1 | Load PC from the bus |
| mar_in | output | 1 | Load memory address register |
| mem_read | output | 1 | Start a memory read |
| alu_carry_in | output | 1 | ALU carry-in set |
| alu_add | output | 1 | ALU function is add |
| z_in | output | 1 | Load ALU result register |
| z_out | output | 1 | Drive ALU result onto the bus |
| mdr_out | output | 1 | Drive memory data register onto the bus |
| ir_in | output | 1 | Load instruction register |
| src_out | output | 1 | Drive source register onto the bus |
| dst_out | output | 1 | Drive destination register onto the bus |
| dst_in | output | 1 | Load destination register |
| y_in | output | 1 | Load ALU operand register |
| offset_out | output | 1 | Drive extended displacement onto the bus |
| wait_mfc | output | 1 | Step waits for memory completion |
| end_o | output | 1 | Last step of the instruction |
| offset_ext | output | 32 | Sign-extended displacement |

## Verification
The assertions assume that ir_opcode is stable from T4 until End, as it is when the instruction register is written only at T3. They also assume that mfc means something only in a waiting step. The bench drives one opcode and one flag value for each whole instruction. It raises mfc only in a waiting step, after a chosen number of stall cycles. It lowers run only between steps. Under these conditions a step never holds for longer than the stimulus allows.

// File: rtl/hwctl_pkg.sv
`timescale 1ns/1ps
package hwctl_pkg;

    localparam int NUM_STEPS = 7;
    localparam int NUM_INSTR = 4;
    localparam int OP_W      = 4;

    // instruction line indices
    localparam int IX_ADD = 0;
    localparam int IX_BR  = 1;
    localparam int IX_BRN = 2;
    localparam int IX_UND = 3;

    localparam logic [OP_W-1:0] OP_ADD = 4'h1;
    localparam logic [OP_W-1:0] OP_BR  = 4'h2;
    localparam logic [OP_W-1:0] OP_BRN = 4'h3;

    typedef enum logic [2:0] {
        ST_T1 = 3'd0,
        ST_T2 = 3'd1,
        ST_T3 = 3'd2,
        ST_T4 = 3'd3,
        ST_T5 = 3'd4,
        ST_T6 = 3'd5,
        ST_T7 = 3'd6
    } step_e;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic mem_read;
        logic carry_in;
        logic alu_add;
        logic z_in;
        logic z_out;
        logic mdr_out;
        logic ir_in;
        logic src_out;
        logic dst_out;
        logic dst_in;
        logic y_in;
        logic offset_out;
        logic wmfc;
        logic fin;
    } ctl_t;

endpackage

// File: rtl/hwctl_step_counter.sv
`timescale 1ns/1ps
module hwctl_step_counter
    import hwctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  wait_req,
    input  logic  mfc,
    input  logic  end_req,
    output step_e step
);

    logic  adv;
    step_e nxt;

    assign adv = run && (!wait_req || mfc);

    always_comb begin
        unique case (step)
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ST_T4;
            ST_T4:   nxt = ST_T5;
            ST_T5:   nxt = ST_T6;
            ST_T6:   nxt = ST_T7;
            ST_T7:   nxt = ST_T1;
            default: nxt = ST_T1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step <= ST_T1;
        else if (adv)
            step <= end_req ? ST_T1 : nxt;
    end

    a_r3_run_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(step));

    a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !mfc) |=> $stable(step));

    a_r12_end_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (run && end_req && (!wait_req || mfc)) |=> (step == ST_T1));

endmodule

// File: rtl/hwctl_step_decoder.sv
`timescale 1ns/1ps
module hwctl_step_decoder
    import hwctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  step_e                step,
    output logic [NUM_STEPS-1:0] t
);

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_slot
        assign t[i] = (step == step_e'(i));
    end

    a_r2_slot_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(t));

endmodule

// File: rtl/hwctl_instr_decoder.sv
`timescale 1ns/1ps
module hwctl_instr_decoder
    import hwctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      opcode,
    output logic [NUM_INSTR-1:0] ins
);

    always_comb begin
        ins = '0;
        unique case (opcode)
            OP_ADD:  ins[IX_ADD] = 1'b1;
            OP_BR:   ins[IX_BR]  = 1'b1;
            OP_BRN:  ins[IX_BRN] = 1'b1;
            default: ins[IX_UND] = 1'b1;
        endcase
    end

    a_r9_instr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ins));

endmodule

// File: rtl/hwctl_encoder.sv
`timescale 1ns/1ps
module hwctl_encoder
    import hwctl_pkg::*;
(
    input  logic [NUM_STEPS-1:0] t,
    input  logic [NUM_INSTR-1:0] ins,
    input  logic                 flag_n,
    output ctl_t                 ctl
);

    logic add_i, br_i, brn_i, und_i, anybr;

    assign add_i = ins[IX_ADD];
    assign br_i  = ins[IX_BR];
    assign brn_i = ins[IX_BRN];
    assign und_i = ins[IX_UND];
    assign anybr = br_i | brn_i;

    // t[0] is T1, t[6] is T7
    always_comb begin
        ctl.pc_out     = t[0] | (t[3] & anybr);
        ctl.pc_in      = t[1] | (t[5] & anybr);
        ctl.mar_in     = t[0] | (t[3] & add_i);
        ctl.mem_read   = t[0] | (t[3] & add_i);
        ctl.carry_in   = t[0];
        ctl.alu_add    = t[0] | (t[5] & add_i) | (t[4] & anybr);
        ctl.z_in       = t[0] | (t[5] & add_i) | (t[4] & anybr);
        ctl.z_out      = t[1] | (t[6] & add_i) | (t[5] & anybr);
        ctl.mdr_out    = t[2] | (t[5] & add_i);
        ctl.ir_in      = t[2];
        ctl.src_out    = t[3] & add_i;
        ctl.dst_out    = t[4] & add_i;
        ctl.dst_in     = t[6] & add_i;
        ctl.y_in       = (t[4] & add_i) | (t[3] & anybr);
        ctl.offset_out = t[4] & anybr;
        ctl.wmfc       = t[1] | (t[4] & add_i);
        ctl.fin        = (t[6] & add_i) | (t[5] & br_i)
                       | (((t[5] & flag_n) | (t[3] & !flag_n)) & brn_i)
                       | (t[3] & und_i);
    end

endmodule

// File: rtl/hwctl_top.sv
`timescale 1ns/1ps
module hwctl_top
    import hwctl_pkg::*;
#(
    parameter int OFF_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [OP_W-1:0]   ir_opcode,
    input  logic [OFF_W-1:0]  ir_offset,
    input  logic              flag_n,
    input  logic              mfc,
    output logic [NUM_STEPS-1:0] step_o,
    output logic              pc_out,
    output logic              pc_in,
    output logic              mar_in,
    output logic              mem_read,
    output logic              alu_carry_in,
    output logic              alu_add,
    output logic              z_in,
    output logic              z_out,
    output logic              mdr_out,
    output logic              ir_in,
    output logic              src_out,
    output logic              dst_out,
    output logic              dst_in,
    output logic              y_in,
    output logic              offset_out,
    output logic              wait_mfc,
    output logic              end_o,
    output logic [DATA_W-1:0] offset_ext
);

    localparam int EXT_W = DATA_W - OFF_W;

    step_e                step;
    logic [NUM_INSTR-1:0] ins;
    ctl_t                 ctl;

    hwctl_step_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .wait_req (ctl.wmfc),
        .mfc      (mfc),
        .end_req  (ctl.fin),
        .step     (step)
    );

    hwctl_step_decoder u_sdec (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .t     (step_o)
    );

    hwctl_instr_decoder u_idec (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_opcode),
        .ins    (ins)
    );

    hwctl_encoder u_enc (
        .t      (step_o),
        .ins    (ins),
        .flag_n (flag_n),
        .ctl    (ctl)
    );

    assign pc_out       = ctl.pc_out;
    assign pc_in        = ctl.pc_in;
    assign mar_in       = ctl.mar_in;
    assign mem_read     = ctl.mem_read;
    assign alu_carry_in = ctl.carry_in;
    assign alu_add      = ctl.alu_add;
    assign z_in         = ctl.z_in;
    assign z_out        = ctl.z_out;
    assign mdr_out      = ctl.mdr_out;
    assign ir_in        = ctl.ir_in;
    assign src_out      = ctl.src_out;
    assign dst_out      = ctl.dst_out;
    assign dst_in       = ctl.dst_in;
    assign y_in         = ctl.y_in;
    assign offset_out   = ctl.offset_out;
    assign wait_mfc     = ctl.wmfc;
    assign end_o        = ctl.fin;

    assign offset_ext = {{EXT_W{ir_offset[OFF_W-1]}}, ir_offset};

    a_r10_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_out, z_out, mdr_out, src_out, dst_out, offset_out}));

    a_r5_fetch_then_load_ir: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o[1] && run && mfc) |=> (ir_in && mdr_out));

    a_r8_brn_clear_ends_t4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o[3] && ir_opcode == OP_BRN && !flag_n) |-> end_o);

endmodule

// File: tb/test_hwctl_top.sv
`timescale 1ns/1ps
module test_hwctl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  ir_opcode = 4'h0;
    logic [7:0]  ir_offset = 8'h00;
    logic        flag_n = 1'b0;
    logic        mfc = 1'b0;
    logic [6:0]  step_o;
    logic pc_out, pc_in, mar_in, mem_read, alu_carry_in, alu_add, z_in, z_out;
    logic mdr_out, ir_in, src_out, dst_out, dst_in, y_in, offset_out, wait_mfc, end_o;
    logic [31:0] offset_ext;

    int tests = 0;
    int fails = 0;
    int mstep = 1;
    logic [3:0] cur_op = 4'h0;
    logic       cur_n  = 1'b0;

    logic [23:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    hwctl_top i_hwctl_top (
        .clk(clk), .rst_n(rst_n), .run(run), .ir_opcode(ir_opcode),
        .ir_offset(ir_offset), .flag_n(flag_n), .mfc(mfc), .step_o(step_o),
        .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_read(mem_read),
        .alu_carry_in(alu_carry_in), .alu_add(alu_add), .z_in(z_in), .z_out(z_out),
        .mdr_out(mdr_out), .ir_in(ir_in), .src_out(src_out), .dst_out(dst_out),
        .dst_in(dst_in), .y_in(y_in), .offset_out(offset_out), .wait_mfc(wait_mfc),
        .end_o(end_o), .offset_ext(offset_ext)
    );

    // bit 16 pc_out .. bit 0 end, from the requirement tables
    function automatic logic [16:0] exp_ctl(input int s, input logic [3:0] op, input logic n);
        logic [16:0] v;
        v = '0;
        case (s)
            1: v = 17'b1_0_1_1_1_1_1_0_0_0_0_0_0_0_0_0_0;
            2: v = 17'b0_1_0_0_0_0_0_1_0_0_0_0_0_0_0_1_0;
            3: v = 17'b0_0_0_0_0_0_0_0_1_1_0_0_0_0_0_0_0;
            default: begin
                if (op == 4'h1) begin
                    case (s)
                        4: begin v[6] = 1; v[14] = 1; v[13] = 1; end
                        5: begin v[5] = 1; v[3] = 1; v[1] = 1; end
                        6: begin v[8] = 1; v[11] = 1; v[10] = 1; end
                        7: begin v[9] = 1; v[4] = 1; v[0] = 1; end
                        default: v = '0;
                    endcase
                end else if (op == 4'h2 || op == 4'h3) begin
                    case (s)
                        4: begin v[16] = 1; v[3] = 1; v[0] = (op == 4'h3) && !n; end
                        5: begin v[2] = 1; v[11] = 1; v[10] = 1; end
                        6: begin v[9] = 1; v[15] = 1; v[0] = 1; end
                        default: v = '0;
                    endcase
                end else begin
                    if (s == 4) v[0] = 1;
                end
            end
        endcase
        return v;
    endfunction

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [23:0] e;
            logic [23:0] a;
            string tg;
            int drv;
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            a  = {pc_out, pc_in, mar_in, mem_read, alu_carry_in, alu_add, z_in, z_out,
                  mdr_out, ir_in, src_out, dst_out, dst_in, y_in, offset_out, wait_mfc,
                  end_o, step_o};
            tests++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: ctl/step actual %b expected %b", tg, a, e);
            end
            drv = $countones({pc_out, z_out, mdr_out, src_out, dst_out, offset_out});
            tests++;
            if (drv > 1) begin
                fails++;
                $display("FAIL R10: bus drivers actual %0d expected <=1", drv);
            end
        end
    end

    // called at posedge+1; ends at the next posedge+1
    task automatic tick(input logic r, input logic m, input string tag);
        logic [16:0] cv;
        run = r;
        mfc = m;
        cv = exp_ctl(mstep, cur_op, cur_n);
        q_exp.push_back({cv, 7'(1 << (mstep - 1))});
        q_tag.push_back(tag);
        @(negedge clk);
        #1;
        if (r && (!cv[1] || m))
            mstep = cv[0] ? 1 : mstep + 1;
        @(posedge clk);
        #1;
    endtask

    task automatic exec(input logic [3:0] op, input logic n, input int stall, input int hold);
        int waited = 0;
        bit held = 0;
        int guard = 0;
        cur_op = op;
        cur_n = n;
        ir_opcode = op;
        flag_n = n;
        while (guard < 100) begin
            logic [16:0] cv;
            logic m;
            string tag;
            guard++;
            cv = exp_ctl(mstep, op, n);
            if (mstep == hold && !held) begin
                tick(1'b0, 1'b0, "R3");
                tick(1'b0, 1'b0, "R3");
                held = 1;
                continue;
            end
            m = cv[1] && (waited >= stall);
            if (cv[1] && !m) tag = "R4";
            else if (mstep == 1) tag = "R12/R5";
            else if (mstep <= 3) tag = "R5/R2";
            else if (op == 4'h1) tag = "R6";
            else if (op == 4'h2) tag = "R7";
            else if (op == 4'h3) tag = "R8";
            else tag = "R9";
            if (cv[1] && !m) waited++;
            tick(1'b1, m, tag);
            if (cv[1] && m) waited = 0;
            if (cv[0]) break;
        end
    endtask

    task automatic check_off(input logic [7:0] off, input logic [31:0] exp);
        ir_offset = off;
        #1;
        tests++;
        if (offset_ext !== exp) begin
            fails++;
            $display("FAIL R11: offset_ext actual %h expected %h", offset_ext, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (step_o !== 7'b0000001 || end_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: step/end actual %b/%b expected 0000001/0", step_o, end_o);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (step_o !== 7'b0000001 || end_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: step/end after reset actual %b/%b expected 0000001/0", step_o, end_o);
        end
        @(posedge clk);
        #1;

        exec(4'h1, 1'b0, 0, 0);   // add, no stall
        exec(4'h1, 1'b1, 3, 0);   // add with memory stalls
        exec(4'h2, 1'b0, 1, 3);   // branch, run low at T3
        exec(4'h3, 1'b1, 0, 5);   // branch-if-negative taken, run low at T5
        exec(4'h3, 1'b0, 2, 0);   // branch-if-negative, ends early
        exec(4'h0, 1'b0, 0, 4);   // undefined, run low at T4
        exec(4'hF, 1'b1, 0, 0);   // undefined
        exec(4'h1, 1'b0, 0, 7);   // add, run low at T7
        exec(4'h2, 1'b1, 0, 0);

        check_off(8'h85, 32'hFFFF_FF85);
        check_off(8'h12, 32'h0000_0012);
        check_off(8'h80, 32'hFFFF_FF80);
        check_off(8'h7F, 32'h0000_007F);

        @(negedge clk);
        #1;
        if (q_exp.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R2: pending items actual %0d expected 0", q_exp.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule